// File: doc/BRIEF.md
# Audio Codec Control Register File

This block is the control and status register set of a stereo audio codec. A serial-link front end hands it one decoded request per cycle: a read or a write, a 7-bit register index, and 16 bits of write data. Only even indices name registers. Writes update the stored fields through a per-register mask, so bits without storage always read back as zero. A read returns its data, together with the index it asked for, on the cycle after the request. The link logic places that data in the following outgoing frame.

Some registers are not plain storage. A write of any value to index 00h returns every register to its default. Reads of 00h and of the two identification registers return fixed codes. The extended-identification register reports two strap pins and variable-rate support. The powerdown register mixes writable powerdown bits with live subsystem-ready inputs. The block also decodes the stored fields into control outputs for the analog path: output attenuations and mutes, mixer gains and mutes, record source and gain, general-purpose switches, powerdown controls, the variable-rate enable and the two sample-rate words. An attenuation field whose top bit is set reports the maximum value of 31.

Top module: `codec_ctrl_regfile`

## Requirements
- R1: While `rst` is high, and after it falls, every register holds its default. Master (02h), line-level (04h) and mono (06h) output volumes are 0x8000. Beep (0Ah) is 0x0000. Phone (0Ch) and mic (0Eh) are 0x8008. Line (10h), CD (12h), video (14h), aux (16h) and PCM (18h) are 0x8808. Record select (1Ah) is 0x0000 and record gain (1Ch) is 0x8000. General (20h), powerdown (26h) and extended control (2Ah) are 0x0000. The rate words (2Ch, 32h) are 0xBB80.
- R2: A write of any data to index 00h restores every register to its R1 default on the next cycle.
- R3: A read request is answered on the next cycle with `rd_valid`=1, `rd_index` equal to the requested index and `rd_data`. A read of 00h returns 0x0D50. `rd_valid` is 0 in cycles that follow no read.
- R4: Index 7Ch reads 0x4E53 and 7Eh reads 0x4300. Writes to either index have no effect.
- R5: Index 26h reads {0, PR[6:0] in bits 14:8, 0000, `sub_ready`[3:0]}. `sub_ready` is live, with ref in bit 3, analog in bit 2, DAC in bit 1 and ADC in bit 0. Only bits 14:8 are writable, and they drive `pd_ctrl`.
- R6: Index 28h is read-only. It reads `strap_id`[1] in bit 15, `strap_id`[0] in bit 14 and 1 in bit 0, with zeros elsewhere.
- R7: Bit 0 of index 2Ah is the variable-rate enable and drives `vra_en`. The other bits of 2Ah read 0.
- R8: Indices 2Ch and 32h store full 16-bit rate words, which drive `dac_rate` and `adc_rate`.
- R9: Index 20h stores bit 15 (`pcm_post3d`), bit 13 (`enh3d_en`), bit 9 (`mono_src_mic`), bit 8 (`mic_sel`) and bit 7 (`loopback`). Writes to 22h have no effect and 22h reads 0.
- R10: Odd indices and indices with no register read 0x0000, and writes to them change no register.
- R11: The output volume registers hold a mute in bit 15, a left attenuation in bits 13:8 and a right attenuation in bits 5:0. The mono register uses only bits 5:0. A reported attenuation equals the field's bits 4:0, or 31 when the field's bit 5 is set. `out_mute` bit 0 is master, bit 1 is line-level and bit 2 is mono.
- R12: Mixer inputs hold a mute in bit 15, a left gain in 12:8 and a right gain in 4:0. Phone and mic use bits 4:0 for both sides. Mic bit 6 drives `mic_boost`. Beep holds its attenuation in bits 4:1. Record select holds left in 10:8 and right in 2:0. Record gain holds mute in bit 15, left in 11:8 and right in 3:0.
- R13: Register bits with no storage read back 0 after a write of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 7 | Register index |
| req_data | input | 16 | Write data |
| strap_id | input | 2 | Codec ID strap pins |
| sub_ready | input | 4 | Subsystem ready flags {ref, analog, dac, adc} |
| rd_valid | output | 1 | Read result valid |
| rd_index | output | 7 | Index echoed with the read result |
| rd_data | output | 16 | Read result |
| out_mute | output | 3 | Mutes {mono, line-level, master} |
| master_att_l | output | 5 | Master left attenuation |
| master_att_r | output | 5 | Master right attenuation |
| lnlvl_att_l | output | 5 | Line-level left attenuation |
| lnlvl_att_r | output | 5 | Line-level right attenuation |
| mono_att | output | 5 | Mono output attenuation |
| in_mute | output | 8 | Mixer mutes {pcm, aux, video, cd, line, mic, phone, beep} |
| mix_gain_l | output | 35 | Left gains; field i is [5i+4:5i], i = phone, mic, line, cd, video, aux, pcm |
| mix_gain_r | output | 35 | Right gains, same order |
| beep_att | output | 4 | Beep attenuation |
| mic_boost | output | 1 | Mic boost enable |
| rec_src_l | output | 3 | Left record source |
| rec_src_r | output | 3 | Right record source |
| rec_mute | output | 1 | Record mute |
| rec_gain_l | output | 4 | Left record gain |
| rec_gain_r | output | 4 | Right record gain |
| pcm_post3d | output | 1 | PCM path after the 3D stage |
| enh3d_en | output | 1 | 3D stage enable |
| mono_src_mic | output | 1 | Mono output takes the mic |
| mic_sel | output | 1 | Second mic selected |
| loopback | output | 1 | ADC-to-DAC loopback |
| pd_ctrl | output | 7 | Powerdown controls PR6..PR0 |
| vra_en | output | 1 | Variable-rate enable |
| dac_rate | output | 16 | DAC sample-rate word |
| adc_rate | output | 16 | ADC sample-rate word |

## Verification
A wrong stored value shows on the decoded control outputs one cycle after the write that caused it. It also shows in the `rd_data` of any read of that index on the cycle after the read. A bad decode of the reset index, or of an odd or unused index, shows as rate words, mutes or powerdown bits that move in the cycle after such a write. A fault in the composite registers (powerdown status, strap identification, constants) appears only in read data. The bench therefore reads each of these after changing the inputs that feed it.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;

    localparam int DATA_W    = 16;
    localparam int IDX_W     = 7;
    localparam int NUM_SLOTS = 18;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int NUM_MIX   = 7;
    localparam int MONO_MIX  = 2;
    localparam int GAIN_W    = 5;
    localparam int ATT_W     = 5;
    localparam int READY_W   = 4;
    localparam int PD_W      = 7;

    localparam int SL_MASTER  = 0;
    localparam int SL_LNLVL   = 1;
    localparam int SL_MONO    = 2;
    localparam int SL_BEEP    = 3;
    localparam int SL_PHONE   = 4;
    localparam int SL_MIC     = 5;
    localparam int SL_LINE    = 6;
    localparam int SL_CD      = 7;
    localparam int SL_VIDEO   = 8;
    localparam int SL_AUX     = 9;
    localparam int SL_PCM     = 10;
    localparam int SL_RECSEL  = 11;
    localparam int SL_RECGAIN = 12;
    localparam int SL_GP      = 13;
    localparam int SL_PWR     = 14;
    localparam int SL_EXTCTL  = 15;
    localparam int SL_DACRATE = 16;
    localparam int SL_ADCRATE = 17;

    localparam logic [IDX_W-1:0]  IX_RESET  = 7'h00;
    localparam logic [IDX_W-1:0]  IX_EXTID  = 7'h28;
    localparam logic [IDX_W-1:0]  IX_VEND1  = 7'h7C;
    localparam logic [IDX_W-1:0]  IX_VEND2  = 7'h7E;
    localparam logic [DATA_W-1:0] CAPS_CODE = 16'h0D50;
    localparam logic [DATA_W-1:0] VEND1_VAL = 16'h4E53;
    localparam logic [DATA_W-1:0] VEND2_VAL = 16'h4300;

    typedef enum logic [2:0] {
        RK_ZERO,
        RK_STORE,
        RK_CONST,
        RK_PWR,
        RK_EXTID
    } rd_kind_e;

    typedef struct packed {
        logic                 hit;
        logic [SLOT_W-1:0]    slot;
        rd_kind_e             kind;
        logic [DATA_W-1:0]    cval;
    } idx_dec_t;

    typedef logic [NUM_SLOTS-1:0][DATA_W-1:0] reg_arr_t;

    function automatic logic [IDX_W-1:0] slot_index(int s);
        case (s)
            SL_MASTER:  return 7'h02;
            SL_LNLVL:   return 7'h04;
            SL_MONO:    return 7'h06;
            SL_BEEP:    return 7'h0A;
            SL_PHONE:   return 7'h0C;
            SL_MIC:     return 7'h0E;
            SL_LINE:    return 7'h10;
            SL_CD:      return 7'h12;
            SL_VIDEO:   return 7'h14;
            SL_AUX:     return 7'h16;
            SL_PCM:     return 7'h18;
            SL_RECSEL:  return 7'h1A;
            SL_RECGAIN: return 7'h1C;
            SL_GP:      return 7'h20;
            SL_PWR:     return 7'h26;
            SL_EXTCTL:  return 7'h2A;
            SL_DACRATE: return 7'h2C;
            default:    return 7'h32;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] slot_default(int s);
        case (s)
            SL_MASTER, SL_LNLVL, SL_MONO, SL_RECGAIN: return 16'h8000;
            SL_PHONE, SL_MIC:                         return 16'h8008;
            SL_LINE, SL_CD, SL_VIDEO, SL_AUX, SL_PCM: return 16'h8808;
            SL_DACRATE, SL_ADCRATE:                   return 16'hBB80;
            default:                                  return 16'h0000;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] slot_mask(int s);
        case (s)
            SL_MASTER, SL_LNLVL:                      return 16'hBF3F;
            SL_MONO:                                  return 16'h803F;
            SL_BEEP:                                  return 16'h801E;
            SL_PHONE:                                 return 16'h801F;
            SL_MIC:                                   return 16'h805F;
            SL_LINE, SL_CD, SL_VIDEO, SL_AUX, SL_PCM: return 16'h9F1F;
            SL_RECSEL:                                return 16'h0707;
            SL_RECGAIN:                               return 16'h8F0F;
            SL_GP:                                    return 16'hA380;
            SL_PWR:                                   return 16'h7F00;
            SL_EXTCTL:                                return 16'h0001;
            default:                                  return 16'hFFFF;
        endcase
    endfunction

    function automatic idx_dec_t decode_index(logic [IDX_W-1:0] idx);
        idx_dec_t d;
        d.hit  = 1'b0;
        d.slot = '0;
        d.kind = RK_ZERO;
        d.cval = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (idx == slot_index(s)) begin
                d.hit  = 1'b1;
                d.slot = SLOT_W'(s);
                d.kind = (s == SL_PWR) ? RK_PWR : RK_STORE;
            end
        end
        case (idx)
            IX_RESET: begin d.kind = RK_CONST; d.cval = CAPS_CODE; end
            IX_VEND1: begin d.kind = RK_CONST; d.cval = VEND1_VAL; end
            IX_VEND2: begin d.kind = RK_CONST; d.cval = VEND2_VAL; end
            IX_EXTID: d.kind = RK_EXTID;
            default: ;
        endcase
        return d;
    endfunction

    function automatic logic [ATT_W-1:0] att_clamp(logic [ATT_W:0] f);
        return f[ATT_W] ? {ATT_W{1'b1}} : f[ATT_W-1:0];
    endfunction

endpackage

// File: rtl/ac_req_decode.sv
module ac_req_decode
    import codec_regs_pkg::*;
(
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [IDX_W-1:0]     req_index,
    output logic [NUM_SLOTS-1:0] wr_en,
    output logic                 clear_all,
    output logic                 rd_req,
    output idx_dec_t             dec
);
    logic do_write;

    always_comb begin
        dec       = decode_index(req_index);
        do_write  = req_valid && req_write;
        rd_req    = req_valid && !req_write;
        clear_all = do_write && (req_index == IX_RESET);
        wr_en     = '0;
        if (do_write && dec.hit)
            wr_en[dec.slot] = 1'b1;
    end
endmodule

// File: rtl/ac_reg_bank.sv
module ac_reg_bank
    import codec_regs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear_all,
    input  logic [NUM_SLOTS-1:0] wr_en,
    input  logic [DATA_W-1:0]    wr_data,
    output reg_arr_t             regs
);
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam logic [DATA_W-1:0] DFLT = slot_default(g);
        localparam logic [DATA_W-1:0] MASK = slot_mask(g);
        always_ff @(posedge clk) begin
            if (rst || clear_all)
                regs[g] <= DFLT;
            else if (wr_en[g])
                regs[g] <= wr_data & MASK;
        end
    end
endmodule

// File: rtl/ac_read_port.sv
module ac_read_port
    import codec_regs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_req,
    input  logic [IDX_W-1:0]   req_index,
    input  idx_dec_t           dec,
    input  reg_arr_t           regs,
    input  logic [1:0]         strap_id,
    input  logic [READY_W-1:0] sub_ready,
    output logic               rd_valid,
    output logic [IDX_W-1:0]   rd_index,
    output logic [DATA_W-1:0]  rd_data
);
    logic [DATA_W-1:0] rd_next;

    always_comb begin
        case (dec.kind)
            RK_STORE: rd_next = regs[dec.slot];
            RK_CONST: rd_next = dec.cval;
            RK_PWR:   rd_next = {regs[SL_PWR][DATA_W-1:8], 4'b0000, sub_ready};
            RK_EXTID: rd_next = {strap_id, {(DATA_W-3){1'b0}}, 1'b1};
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_index <= '0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) begin
                rd_index <= req_index;
                rd_data  <= rd_next;
            end
        end
    end
endmodule

// File: rtl/ac_field_decode.sv
module ac_field_decode
    import codec_regs_pkg::*;
(
    input  reg_arr_t                    regs,
    output logic [2:0]                  out_mute,
    output logic [ATT_W-1:0]            master_att_l,
    output logic [ATT_W-1:0]            master_att_r,
    output logic [ATT_W-1:0]            lnlvl_att_l,
    output logic [ATT_W-1:0]            lnlvl_att_r,
    output logic [ATT_W-1:0]            mono_att,
    output logic [NUM_MIX:0]            in_mute,
    output logic [NUM_MIX*GAIN_W-1:0]   mix_gain_l,
    output logic [NUM_MIX*GAIN_W-1:0]   mix_gain_r,
    output logic [3:0]                  beep_att,
    output logic                        mic_boost,
    output logic [2:0]                  rec_src_l,
    output logic [2:0]                  rec_src_r,
    output logic                        rec_mute,
    output logic [3:0]                  rec_gain_l,
    output logic [3:0]                  rec_gain_r,
    output logic                        pcm_post3d,
    output logic                        enh3d_en,
    output logic                        mono_src_mic,
    output logic                        mic_sel,
    output logic                        loopback,
    output logic [PD_W-1:0]             pd_ctrl,
    output logic                        vra_en,
    output logic [DATA_W-1:0]           dac_rate,
    output logic [DATA_W-1:0]           adc_rate
);
    always_comb begin
        out_mute     = {regs[SL_MONO][15], regs[SL_LNLVL][15], regs[SL_MASTER][15]};
        master_att_l = att_clamp(regs[SL_MASTER][13:8]);
        master_att_r = att_clamp(regs[SL_MASTER][5:0]);
        lnlvl_att_l  = att_clamp(regs[SL_LNLVL][13:8]);
        lnlvl_att_r  = att_clamp(regs[SL_LNLVL][5:0]);
        mono_att     = att_clamp(regs[SL_MONO][5:0]);
        in_mute[0]   = regs[SL_BEEP][15];
        beep_att     = regs[SL_BEEP][4:1];
        mic_boost    = regs[SL_MIC][6];
        rec_src_l    = regs[SL_RECSEL][10:8];
        rec_src_r    = regs[SL_RECSEL][2:0];
        rec_mute     = regs[SL_RECGAIN][15];
        rec_gain_l   = regs[SL_RECGAIN][11:8];
        rec_gain_r   = regs[SL_RECGAIN][3:0];
        pcm_post3d   = regs[SL_GP][15];
        enh3d_en     = regs[SL_GP][13];
        mono_src_mic = regs[SL_GP][9];
        mic_sel      = regs[SL_GP][8];
        loopback     = regs[SL_GP][7];
        pd_ctrl      = regs[SL_PWR][14:8];
        vra_en       = regs[SL_EXTCTL][0];
        dac_rate     = regs[SL_DACRATE];
        adc_rate     = regs[SL_ADCRATE];
    end

    for (genvar i = 0; i < NUM_MIX; i++) begin : g_mix
        localparam int SL = SL_PHONE + i;
        assign in_mute[i+1] = regs[SL][15];
        if (i < MONO_MIX) begin : g_mono
            assign mix_gain_l[i*GAIN_W +: GAIN_W] = regs[SL][GAIN_W-1:0];
            assign mix_gain_r[i*GAIN_W +: GAIN_W] = regs[SL][GAIN_W-1:0];
        end else begin : g_stereo
            assign mix_gain_l[i*GAIN_W +: GAIN_W] = regs[SL][8 +: GAIN_W];
            assign mix_gain_r[i*GAIN_W +: GAIN_W] = regs[SL][GAIN_W-1:0];
        end
    end
endmodule

// File: rtl/codec_ctrl_regfile.sv
module codec_ctrl_regfile
    import codec_regs_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [IDX_W-1:0]            req_index,
    input  logic [DATA_W-1:0]           req_data,
    input  logic [1:0]                  strap_id,
    input  logic [READY_W-1:0]          sub_ready,
    output logic                        rd_valid,
    output logic [IDX_W-1:0]            rd_index,
    output logic [DATA_W-1:0]           rd_data,
    output logic [2:0]                  out_mute,
    output logic [ATT_W-1:0]            master_att_l,
    output logic [ATT_W-1:0]            master_att_r,
    output logic [ATT_W-1:0]            lnlvl_att_l,
    output logic [ATT_W-1:0]            lnlvl_att_r,
    output logic [ATT_W-1:0]            mono_att,
    output logic [NUM_MIX:0]            in_mute,
    output logic [NUM_MIX*GAIN_W-1:0]   mix_gain_l,
    output logic [NUM_MIX*GAIN_W-1:0]   mix_gain_r,
    output logic [3:0]                  beep_att,
    output logic                        mic_boost,
    output logic [2:0]                  rec_src_l,
    output logic [2:0]                  rec_src_r,
    output logic                        rec_mute,
    output logic [3:0]                  rec_gain_l,
    output logic [3:0]                  rec_gain_r,
    output logic                        pcm_post3d,
    output logic                        enh3d_en,
    output logic                        mono_src_mic,
    output logic                        mic_sel,
    output logic                        loopback,
    output logic [PD_W-1:0]             pd_ctrl,
    output logic                        vra_en,
    output logic [DATA_W-1:0]           dac_rate,
    output logic [DATA_W-1:0]           adc_rate
);
    logic [NUM_SLOTS-1:0] wr_en;
    logic                 clear_all;
    logic                 rd_req;
    idx_dec_t             dec;
    reg_arr_t             regs;

    ac_req_decode dec_i (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_index (req_index),
        .wr_en     (wr_en),
        .clear_all (clear_all),
        .rd_req    (rd_req),
        .dec       (dec)
    );

    ac_reg_bank bank_i (
        .clk       (clk),
        .rst       (rst),
        .clear_all (clear_all),
        .wr_en     (wr_en),
        .wr_data   (req_data),
        .regs      (regs)
    );

    ac_read_port rdp_i (
        .clk       (clk),
        .rst       (rst),
        .rd_req    (rd_req),
        .req_index (req_index),
        .dec       (dec),
        .regs      (regs),
        .strap_id  (strap_id),
        .sub_ready (sub_ready),
        .rd_valid  (rd_valid),
        .rd_index  (rd_index),
        .rd_data   (rd_data)
    );

    ac_field_decode fld_i (
        .regs         (regs),
        .out_mute     (out_mute),
        .master_att_l (master_att_l),
        .master_att_r (master_att_r),
        .lnlvl_att_l  (lnlvl_att_l),
        .lnlvl_att_r  (lnlvl_att_r),
        .mono_att     (mono_att),
        .in_mute      (in_mute),
        .mix_gain_l   (mix_gain_l),
        .mix_gain_r   (mix_gain_r),
        .beep_att     (beep_att),
        .mic_boost    (mic_boost),
        .rec_src_l    (rec_src_l),
        .rec_src_r    (rec_src_r),
        .rec_mute     (rec_mute),
        .rec_gain_l   (rec_gain_l),
        .rec_gain_r   (rec_gain_r),
        .pcm_post3d   (pcm_post3d),
        .enh3d_en     (enh3d_en),
        .mono_src_mic (mono_src_mic),
        .mic_sel      (mic_sel),
        .loopback     (loopback),
        .pd_ctrl      (pd_ctrl),
        .vra_en       (vra_en),
        .dac_rate     (dac_rate),
        .adc_rate     (adc_rate)
    );
endmodule

// File: rtl/codec_ctrl_regfile_chk.sv
module codec_ctrl_regfile_chk
    import codec_regs_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_write,
    input logic [IDX_W-1:0]   req_index,
    input logic               rd_valid,
    input logic [IDX_W-1:0]   rd_index,
    input logic [DATA_W-1:0]  rd_data,
    input logic [2:0]         out_mute,
    input logic [PD_W-1:0]    pd_ctrl,
    input logic               vra_en,
    input logic [DATA_W-1:0]  dac_rate
);
    // R3
    rd_answer_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> (rd_valid && rd_index == $past(req_index)));

    // R3
    rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rd_valid);

    // R2
    soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_index == IX_RESET) |=>
        (dac_rate == 16'hBB80 && !vra_en && out_mute == 3'b111 && pd_ctrl == '0));

    // R4
    vendor_id_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_index == IX_VEND1) |-> rd_data == VEND1_VAL);

    // R6
    ext_id_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_index == IX_EXTID) |-> rd_data[13:0] == 14'h0001);

    // R5
    pwr_status_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_index == 7'h26) |-> (rd_data[7:4] == 4'h0 && !rd_data[15]));

    // R10
    odd_write_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_index[0]) |=>
        ($stable(dac_rate) && $stable(pd_ctrl) && $stable(vra_en) && $stable(out_mute)));
endmodule

bind codec_ctrl_regfile codec_ctrl_regfile_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_index (req_index),
    .rd_valid  (rd_valid),
    .rd_index  (rd_index),
    .rd_data   (rd_data),
    .out_mute  (out_mute),
    .pd_ctrl   (pd_ctrl),
    .vra_en    (vra_en),
    .dac_rate  (dac_rate)
);

// File: tb/codec_ctrl_regfile_tb_top.sv
`timescale 1ns/1ps
module codec_ctrl_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [6:0]  req_index = '0;
    logic [15:0] req_data = '0;
    logic [1:0]  strap_id = 2'b00;
    logic [3:0]  sub_ready = 4'b0000;
    logic        rd_valid;
    logic [6:0]  rd_index;
    logic [15:0] rd_data;
    logic [2:0]  out_mute;
    logic [4:0]  master_att_l, master_att_r, lnlvl_att_l, lnlvl_att_r, mono_att;
    logic [7:0]  in_mute;
    logic [34:0] mix_gain_l, mix_gain_r;
    logic [3:0]  beep_att;
    logic        mic_boost;
    logic [2:0]  rec_src_l, rec_src_r;
    logic        rec_mute;
    logic [3:0]  rec_gain_l, rec_gain_r;
    logic        pcm_post3d, enh3d_en, mono_src_mic, mic_sel, loopback;
    logic [6:0]  pd_ctrl;
    logic        vra_en;
    logic [15:0] dac_rate, adc_rate;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    codec_ctrl_regfile dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_index(req_index), .req_data(req_data), .strap_id(strap_id),
        .sub_ready(sub_ready), .rd_valid(rd_valid), .rd_index(rd_index),
        .rd_data(rd_data), .out_mute(out_mute), .master_att_l(master_att_l),
        .master_att_r(master_att_r), .lnlvl_att_l(lnlvl_att_l),
        .lnlvl_att_r(lnlvl_att_r), .mono_att(mono_att), .in_mute(in_mute),
        .mix_gain_l(mix_gain_l), .mix_gain_r(mix_gain_r), .beep_att(beep_att),
        .mic_boost(mic_boost), .rec_src_l(rec_src_l), .rec_src_r(rec_src_r),
        .rec_mute(rec_mute), .rec_gain_l(rec_gain_l), .rec_gain_r(rec_gain_r),
        .pcm_post3d(pcm_post3d), .enh3d_en(enh3d_en), .mono_src_mic(mono_src_mic),
        .mic_sel(mic_sel), .loopback(loopback), .pd_ctrl(pd_ctrl),
        .vra_en(vra_en), .dac_rate(dac_rate), .adc_rate(adc_rate)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(logic [6:0] idx, logic [15:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_index = idx; req_data = data;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_data = '0;
    endtask

    task automatic do_read(string req, logic [6:0] idx, logic [15:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_index = idx;
        @(negedge clk);
        req_valid = 1'b0;
        check("R3", "rd_valid", rd_valid, 1);
        check("R3", "rd_index", rd_index, idx);
        check(req, $sformatf("read %0h", idx), rd_data, exp);
    endtask

    task automatic t_reset_state;
        check("R1", "out_mute", out_mute, 3'b111);
        check("R1", "in_mute", in_mute, 8'hFE);
        for (int i = 0; i < 7; i++) begin
            check("R1", "gain_l", mix_gain_l[i*5 +: 5], 5'd8);
            check("R1", "gain_r", mix_gain_r[i*5 +: 5], 5'd8);
        end
        check("R1", "rec_mute", rec_mute, 1);
        check("R1", "dac_rate", dac_rate, 16'hBB80);
        check("R1", "adc_rate", adc_rate, 16'hBB80);
        check("R1", "pd_ctrl", pd_ctrl, 0);
        check("R3", "rd_valid idle", rd_valid, 0);
        do_read("R1", 7'h02, 16'h8000);
        do_read("R1", 7'h06, 16'h8000);
        do_read("R1", 7'h0C, 16'h8008);
        do_read("R1", 7'h14, 16'h8808);
        do_read("R1", 7'h1A, 16'h0000);
        do_read("R1", 7'h1C, 16'h8000);
        do_read("R1", 7'h32, 16'hBB80);
    endtask

    task automatic t_caps_and_vendor;
        do_read("R3", 7'h00, 16'h0D50);
        do_write(7'h7C, 16'hFFFF);
        check("R3", "rd_valid after write", rd_valid, 0);
        do_write(7'h7E, 16'h0000);
        do_read("R4", 7'h7C, 16'h4E53);
        do_read("R4", 7'h7E, 16'h4300);
    endtask

    task automatic t_out_volume;
        do_write(7'h02, 16'h0A05);
        check("R11", "master_att_l", master_att_l, 10);
        check("R11", "master_att_r", master_att_r, 5);
        check("R11", "master mute", out_mute[0], 0);
        do_read("R11", 7'h02, 16'h0A05);
        do_write(7'h04, 16'hFFFF);
        check("R11", "lnlvl_att_l", lnlvl_att_l, 31);
        check("R11", "lnlvl_att_r", lnlvl_att_r, 31);
        check("R11", "lnlvl mute", out_mute[1], 1);
        do_read("R13", 7'h04, 16'hBF3F);
        do_write(7'h06, 16'h0020);
        check("R11", "mono_att clamp", mono_att, 31);
        check("R11", "mono mute", out_mute[2], 0);
    endtask

    task automatic t_mixer;
        do_write(7'h10, 16'h1F03);
        check("R12", "line gain_l", mix_gain_l[10 +: 5], 31);
        check("R12", "line gain_r", mix_gain_r[10 +: 5], 3);
        check("R12", "line mute", in_mute[3], 0);
        do_write(7'h0E, 16'h0045);
        check("R12", "mic gain_l", mix_gain_l[5 +: 5], 5);
        check("R12", "mic gain_r", mix_gain_r[5 +: 5], 5);
        check("R12", "mic_boost", mic_boost, 1);
        check("R12", "mic mute", in_mute[2], 0);
        do_write(7'h0A, 16'h801E);
        check("R12", "beep_att", beep_att, 15);
        check("R12", "beep mute", in_mute[0], 1);
        do_write(7'h1A, 16'hFFFF);
        check("R12", "rec_src_l", rec_src_l, 7);
        check("R12", "rec_src_r", rec_src_r, 7);
        do_read("R13", 7'h1A, 16'h0707);
        do_write(7'h1C, 16'h0F05);
        check("R12", "rec_gain_l", rec_gain_l, 15);
        check("R12", "rec_gain_r", rec_gain_r, 5);
        check("R12", "rec_mute", rec_mute, 0);
    endtask

    task automatic t_general;
        do_write(7'h20, 16'hFFFF);
        check("R9", "gp fields", {pcm_post3d, enh3d_en, mono_src_mic, mic_sel, loopback}, 5'h1F);
        do_read("R13", 7'h20, 16'hA380);
        do_write(7'h22, 16'hFFFF);
        do_read("R9", 7'h22, 16'h0000);
        do_read("R9", 7'h20, 16'hA380);
        do_write(7'h20, 16'h2000);
        check("R9", "gp 3d only", {pcm_post3d, enh3d_en, mono_src_mic, mic_sel, loopback}, 5'b01000);
    endtask

    task automatic t_power;
        sub_ready = 4'b1010;
        do_write(7'h26, 16'hFFFF);
        check("R5", "pd_ctrl", pd_ctrl, 7'h7F);
        do_read("R5", 7'h26, 16'h7F0A);
        sub_ready = 4'b0101;
        do_read("R5", 7'h26, 16'h7F05);
        do_write(7'h26, 16'h0A00);
        do_read("R5", 7'h26, 16'h0A05);
    endtask

    task automatic t_ext_id;
        strap_id = 2'b10;
        do_read("R6", 7'h28, 16'h8001);
        strap_id = 2'b01;
        do_read("R6", 7'h28, 16'h4001);
        strap_id = 2'b00;
        do_write(7'h28, 16'hFFFF);
        do_read("R6", 7'h28, 16'h0001);
    endtask

    task automatic t_rate;
        do_write(7'h2A, 16'hFFFF);
        check("R7", "vra_en", vra_en, 1);
        do_read("R7", 7'h2A, 16'h0001);
        do_write(7'h2C, 16'h1234);
        check("R8", "dac_rate", dac_rate, 16'h1234);
        do_write(7'h32, 16'h5622);
        check("R8", "adc_rate", adc_rate, 16'h5622);
        do_read("R8", 7'h2C, 16'h1234);
    endtask

    task automatic t_unimpl;
        do_write(7'h2D, 16'hFFFF);
        do_write(7'h03, 16'h0000);
        do_write(7'h40, 16'h0000);
        check("R10", "dac_rate kept", dac_rate, 16'h1234);
        check("R10", "vra kept", vra_en, 1);
        check("R10", "out_mute kept", out_mute, 3'b010);
        do_read("R10", 7'h03, 16'h0000);
        do_read("R10", 7'h40, 16'h0000);
        do_read("R10", 7'h2C, 16'h1234);
    endtask

    task automatic t_soft_reset;
        do_write(7'h00, 16'hABCD);
        check("R2", "dac_rate", dac_rate, 16'hBB80);
        check("R2", "adc_rate", adc_rate, 16'hBB80);
        check("R2", "vra_en", vra_en, 0);
        check("R2", "out_mute", out_mute, 3'b111);
        check("R2", "pd_ctrl", pd_ctrl, 0);
        check("R2", "in_mute", in_mute, 8'hFE);
        do_read("R2", 7'h02, 16'h8000);
        do_read("R2", 7'h20, 16'h0000);
        do_read("R2", 7'h10, 16'h8808);
    endtask

    task automatic t_hw_reset;
        do_write(7'h2C, 16'h0001);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1", "dac_rate in reset", dac_rate, 16'hBB80);
        rst = 1'b0;
        do_read("R1", 7'h2C, 16'hBB80);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_caps_and_vendor();
        t_out_volume();
        t_mixer();
        t_general();
        t_power();
        t_ext_id();
        t_rate();
        t_unimpl();
        t_soft_reset();
        t_hw_reset();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule